// File: doc/BRIEF.md
# Delay Code Program Interface

This block produces the 8-bit code that selects the tap of a downstream programmable delay line. A mode pin selects how the code is supplied. In parallel operation the code comes from eight program pins. While the enable pin is high the code follows the pins. When the enable falls, the value on the pins is held until the enable goes high again.

In serial operation an 8-bit input register is loaded one bit per rising edge of a serial clock, most significant bit first, while the enable is high. The bits that were in the register before leave on a serial output, also most significant bit first, so several units can be chained. The same mechanism reads the register back. The read is destructive, and the original contents must be shifted back in if they are to be kept. The active code takes the register value only when the enable falls.

The serial clock, the enable and the serial data are sampled by a fast system clock through a synchronizer chain and then edge-detected. A one-cycle pulse marks every change of the active code, so the delay line can react to it.

Top module: `dly_code_ctrl`

## Requirements
- R1: With mode_i=1 and the enable high, code_o follows par_i. Bit 7 of par_i is the most significant bit of the code. A pin change reaches code_o a fixed number of system clocks later.
- R2: With mode_i=1 and the enable low, changes on par_i do not affect code_o. The value on par_i when the enable falls is the value that is held.
- R3: With mode_i=0 and the enable high, each rising edge of sclk_i shifts the input register left by one place and puts sdi_i into bit 0. A partial transfer of n bits leaves the old contents shifted left by n places.
- R4: In serial mode code_o stays unchanged while the enable is high and the serial clock toggles. On the falling edge of the enable, code_o takes the value of the input register.
- R5: After the enable rises in serial mode, and before any serial clock edge, sdo_o shows bit 7 of the input register. After each rising edge of the serial clock, sdo_o shows the next lower of the old bits.
- R6: A read is destructive: the bits shifted in replace the bits shifted out. Shifting every bit read back into the register before the enable falls leaves code_o unchanged and produces no update pulse.
- R7: sdo_oe_o is 1 only when mode_i=0 and the enable is high. Otherwise sdo_oe_o is 0 and sdo_o is high-impedance.
- R8: Serial clock edges change nothing when the enable is low or when mode_i=1.
- R9: code_update_o is high for exactly one system clock in the cycle in which code_o first shows a new value, and it is never high when code_o is unchanged.
- R10: During reset, code_o, the input register, code_update_o and sdo_oe_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 = parallel operation, 0 = serial operation |
| en_i | input | 1 | Enable: transparency or latch in parallel mode, transfer window in serial mode |
| par_i | input | CODE_W | Parallel program pins |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, high-impedance when not enabled |
| sdo_oe_o | output | 1 | Drive enable for the serial output |
| code_o | output | CODE_W | Active delay code |
| code_update_o | output | 1 | One-cycle pulse on each code change |

## Verification
The bench builds the block with CODE_W=8 and SYNC_STAGES=2, so a full serial transfer and its read-back take only a few hundred cycles. This lets one run cover transparent following, latching, full and partial shifts, write-back reads and ignored clocks. Every code change the stimulus should cause is queued. Each update pulse must match the head of the queue, so a pulse that is missing, an extra pulse or a wrong code is reported.

// File: rtl/dly_code_pkg.sv
package dly_code_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;

    // Encoding is {mode, enable level}
    typedef enum logic [1:0] {
        OP_SER_IDLE   = 2'b00,
        OP_SER_WINDOW = 2'b01,
        OP_PAR_HOLD   = 2'b10,
        OP_PAR_FOLLOW = 2'b11
    } op_e;

endpackage

// File: rtl/dly_sync_chain.sv
module dly_sync_chain #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/dly_edge_det.sv
module dly_edge_det #(
    parameter dly_code_pkg::edge_kind_e KIND = dly_code_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic pulse_o
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    generate
        if (KIND == dly_code_pkg::EDGE_RISE) begin : g_rise
            assign pulse_o = lvl_i & ~prev_q;
        end else begin : g_fall
            assign pulse_o = ~lvl_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/dly_shift_reg.sv
module dly_shift_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sdi_i,
    output logic [CODE_W-1:0] sreg_o
);
    logic [CODE_W-1:0] sreg_d, sreg_q;

    always_comb begin
        sreg_d = sreg_q;
        if (shift_i) sreg_d = {sreg_q[CODE_W-2:0], sdi_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sreg_q <= '0;
        else        sreg_q <= sreg_d;
    end

    assign sreg_o = sreg_q;
endmodule

// File: rtl/dly_code_reg.sv
module dly_code_reg
    import dly_code_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op_i,
    input  logic              en_fall_i,
    input  logic [CODE_W-1:0] par_i,
    input  logic [CODE_W-1:0] sreg_i,
    output logic [CODE_W-1:0] code_o,
    output logic              update_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              upd;
    } code_state_t;

    code_state_t st_d, st_q;

    always_comb begin
        st_d.code = st_q.code;
        unique case (op_i)
            OP_PAR_FOLLOW: st_d.code = par_i;
            OP_PAR_HOLD:   if (en_fall_i) st_d.code = par_i;
            OP_SER_IDLE:   if (en_fall_i) st_d.code = sreg_i;
            OP_SER_WINDOW: st_d.code = st_q.code;
            default:       st_d.code = st_q.code;
        endcase
        st_d.upd = (st_d.code != st_q.code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0};
        else        st_q <= st_d;
    end

    assign code_o   = st_q.code;
    assign update_o = st_q.upd;
endmodule

// File: rtl/dly_code_ctrl.sv
module dly_code_ctrl
    import dly_code_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              en_i,
    input  logic [CODE_W-1:0] par_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic [CODE_W-1:0] code_o,
    output logic              code_update_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, synced;
    logic              en_lvl, sclk_lvl, sdi_lvl;
    logic              sclk_rise, en_fall;
    logic              shift_en;
    logic [CODE_W-1:0] sreg;
    op_e               op;

    assign raw_in = {sdi_i, sclk_i, en_i};

    dly_sync_chain #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din_i(raw_in), .dout_o(synced)
    );

    assign en_lvl   = synced[0];
    assign sclk_lvl = synced[1];
    assign sdi_lvl  = synced[2];

    dly_edge_det #(.KIND(EDGE_RISE)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_lvl), .pulse_o(sclk_rise)
    );

    dly_edge_det #(.KIND(EDGE_FALL)) u_en_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(en_lvl), .pulse_o(en_fall)
    );

    always_comb begin
        op       = op_e'({mode_i, en_lvl});
        shift_en = (op == OP_SER_WINDOW) && sclk_rise;
    end

    dly_shift_reg #(.CODE_W(CODE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_i(shift_en), .sdi_i(sdi_lvl),
        .sreg_o(sreg)
    );

    dly_code_reg #(.CODE_W(CODE_W)) u_code (
        .clk(clk), .rst_n(rst_n), .op_i(op), .en_fall_i(en_fall),
        .par_i(par_i), .sreg_i(sreg), .code_o(code_o),
        .update_o(code_update_o)
    );

    assign sdo_oe_o = (op == OP_SER_WINDOW);
    assign sdo_o    = sdo_oe_o ? sreg[CODE_W-1] : 1'bz;
endmodule

// File: rtl/dly_code_ctrl_checker.sv
module dly_code_ctrl_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_i,
    input logic              en_lvl,
    input logic [CODE_W-1:0] par_i,
    input logic              sdo_oe_o,
    input logic [CODE_W-1:0] code_o,
    input logic              code_update_o
);
    p_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && en_lvl) |=> (code_o == $past(par_i)));

    p_serial_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !sdo_oe_o && $past(!sdo_oe_o) && $past(!sdo_oe_o, 2))
        |-> $stable(code_o));

    p_oe_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe_o |-> (!mode_i && en_lvl));

    p_update_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (code_o != $past(code_o)) |-> code_update_o);

    p_update_only_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_update_o |-> (code_o != $past(code_o)));
endmodule

bind dly_code_ctrl dly_code_ctrl_checker #(.CODE_W(CODE_W)) u_checker (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_lvl(en_lvl),
    .par_i(par_i), .sdo_oe_o(sdo_oe_o), .code_o(code_o),
    .code_update_o(code_update_o)
);

// File: tb/dly_code_ctrl_bench.sv
module dly_code_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] par = '0;
    logic         sclk = 1'b0;
    logic         sdi = 1'b0;
    wire          sdo;
    logic         sdo_oe;
    logic [W-1:0] code;
    logic         upd;

    dly_code_ctrl #(.CODE_W(W), .SYNC_STAGES(2)) u_dly_code_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .en_i(en), .par_i(par),
        .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .code_o(code), .code_update_o(upd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;

    exp_t         exp_q[$];
    logic [W-1:0] model_code = '0;
    logic [W-1:0] model_sreg = '0;
    int           n_checks = 0;
    int           n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_code(input logic [W-1:0] v, input string req);
        exp_t e;
        if (v != model_code) begin
            e.val = v;
            e.req = req;
            exp_q.push_back(e);
            model_code = v;
        end
    endtask

    // Monitor: every update pulse must match the oldest queued change (R9)
    always @(negedge clk) begin
        if (rst_n && upd) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected update, code", int'(code), int'(model_code));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(code == e.val, e.req, "code at update pulse", int'(code), int'(e.val));
            end
        end
    end

    task automatic set_en(input logic v);
        en = v;
        cyc(6);
    endtask

    task automatic sclk_pulse(input logic d);
        sdi = d;
        cyc(3);
        sclk = 1'b1;
        cyc(4);
        sclk = 1'b0;
        cyc(3);
    endtask

    // Shift wdata in MSB first; returns what came out on sdo
    task automatic xfer(input logic [W-1:0] wdata, input string req, output logic [W-1:0] rdata);
        for (int i = W-1; i >= 0; i--) begin
            rdata[i] = sdo;
            sclk_pulse(wdata[i]);
            model_sreg = {model_sreg[W-2:0], wdata[i]};
        end
        check(sdo_oe == 1'b1, req, "oe during transfer", int'(sdo_oe), 1);
    endtask

    // Read each bit and shift it straight back in
    task automatic readback(output logic [W-1:0] rdata);
        for (int i = W-1; i >= 0; i--) begin
            logic b;
            b = sdo;
            rdata[i] = b;
            sclk_pulse(b);
            model_sreg = {model_sreg[W-2:0], b};
        end
    endtask

    initial begin
        logic [W-1:0] rd;
        cyc(4);
        check(code == '0, "R10", "code in reset", int'(code), 0);
        check(upd == 1'b0, "R10", "update in reset", int'(upd), 0);
        check(sdo_oe == 1'b0, "R10", "oe in reset", int'(sdo_oe), 0);
        rst_n = 1'b1;
        cyc(3);

        // Transparent parallel (R1)
        mode = 1'b1;
        set_en(1'b1);
        check(sdo_oe == 1'b0, "R7", "oe in parallel mode", int'(sdo_oe), 0);
        par = 8'h5A; expect_code(8'h5A, "R1"); cyc(3);
        check(code == 8'h5A, "R1", "code follows pins", int'(code), 8'h5A);
        par = 8'hFF; expect_code(8'hFF, "R1"); cyc(3);
        par = 8'h01; expect_code(8'h01, "R1"); cyc(3);
        check(code == 8'h01, "R1", "code follows pins", int'(code), 8'h01);

        // Serial clock ignored in parallel mode (R8)
        sclk_pulse(1'b1); sclk_pulse(1'b1);
        check(code == 8'h01, "R8", "code after sclk in parallel", int'(code), 8'h01);

        // Latched parallel (R2)
        set_en(1'b0);
        par = 8'h77; cyc(6);
        check(code == 8'h01, "R2", "pins ignored while latched", int'(code), 8'h01);
        par = 8'h34;
        en = 1'b1; expect_code(8'h34, "R2"); cyc(6);
        set_en(1'b0);
        par = 8'h99; cyc(6);
        check(code == 8'h34, "R2", "held value after fall", int'(code), 8'h34);

        // Serial write (R3, R4, R5, R8)
        mode = 1'b0; cyc(2);
        check(sdo_oe == 1'b0, "R7", "oe with enable low", int'(sdo_oe), 0);
        set_en(1'b1);
        check(sdo_oe == 1'b1, "R7", "oe in serial window", int'(sdo_oe), 1);
        xfer(8'hA5, "R3", rd);
        check(rd == 8'h00, "R8", "register untouched by parallel-mode sclk", int'(rd), 0);
        check(code == 8'h34, "R4", "code held during shift", int'(code), 8'h34);
        en = 1'b0; expect_code(model_sreg, "R4"); cyc(6);
        check(code == 8'hA5, "R4", "code after enable fall", int'(code), 8'hA5);

        // sclk while enable low ignored (R8)
        sclk_pulse(1'b1); sclk_pulse(1'b0); sclk_pulse(1'b1);

        // Non-destructive use via write-back (R5, R6)
        set_en(1'b1);
        check(sdo == 1'b1, "R5", "msb shown before clocks", int'(sdo), 1);
        readback(rd);
        check(rd == 8'hA5, "R5", "read-back sequence", int'(rd), 8'hA5);
        set_en(1'b0);
        check(code == 8'hA5, "R6", "write-back keeps code", int'(code), 8'hA5);

        // Destructive read (R6)
        set_en(1'b1);
        xfer(8'h3C, "R6", rd);
        check(rd == 8'hA5, "R6", "old bits out while new in", int'(rd), 8'hA5);
        en = 1'b0; expect_code(model_sreg, "R6"); cyc(6);
        check(code == 8'h3C, "R6", "new code after fall", int'(code), 8'h3C);

        // Partial shift (R3)
        set_en(1'b1);
        check(sdo == 1'b0, "R5", "bit7 of 3C", int'(sdo), 0);
        sclk_pulse(1'b1); model_sreg = {model_sreg[W-2:0], 1'b1};
        check(sdo == 1'b0, "R5", "bit6 of 3C", int'(sdo), 0);
        sclk_pulse(1'b0); model_sreg = {model_sreg[W-2:0], 1'b0};
        check(sdo == 1'b1, "R5", "bit5 of 3C", int'(sdo), 1);
        sclk_pulse(1'b1); model_sreg = {model_sreg[W-2:0], 1'b1};
        en = 1'b0; expect_code(model_sreg, "R3"); cyc(6);
        check(code == 8'hE5, "R3", "partial shift result", int'(code), 8'hE5);

        set_en(1'b1);
        readback(rd);
        check(rd == 8'hE5, "R3", "register after partial shift", int'(rd), 8'hE5);
        set_en(1'b0);

        // Back to parallel
        mode = 1'b1; cyc(2);
        en = 1'b1; expect_code(8'h99, "R1"); cyc(6);
        check(code == 8'h99, "R1", "follow after mode switch", int'(code), 8'h99);
        cyc(10);

        check(exp_q.size() == 0, "R9", "missing update pulses", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule